// File: doc/BRIEF.md
# Completion Interrupt Coalescer

This unit produces the interrupt line of one DMA channel. It combines three event sources into that line: finished packets, a timeout after packet activity stops, and bus errors. Each packet completion counts down a completion counter that starts at a programmed threshold. When the counter runs out, a completion event is flagged. Each completion also restarts an inactivity timer, so that a trickle of packets below the threshold still raises an interrupt once the channel goes quiet.

The surrounding channel logic supplies a one-cycle pulse per finished packet and a one-cycle pulse per error. It also supplies the threshold and timeout fields of its control word, a control-write strobe, per-source enables, write-one-to-clear strobes and a prescaled tick. The unit returns the three pending flags, the live counter and timer values for the status word, and the level interrupt line. Pending vector bit order: bit 0 completion, bit 1 delay timeout, bit 2 error.

Top module: `icu_coalesce`

## Requirements
- R1: After reset the pending vector is 0, the live count is RST_COUNT (default 1), the live timer is 0 and the interrupt line is low.
- R2: A completion pulse with no control write decrements the live count. If the count is 1 or less before the pulse, the pulse instead sets pending bit 0 and reloads the count from the threshold input.
- R3: A control write loads the live count from the threshold input. In that cycle it overrides any completion: there is no decrement and pending bit 0 is not set.
- R4: A completion pulse with a nonzero timeout input loads the live timer with that timeout. A completion with a zero timeout leaves the timer alone.
- R5: When no timer load occurs, each tick pulse decrements a nonzero live timer by one. Without a tick the timer holds, and a timer at zero stays at zero.
- R6: A tick that takes the timer from 1 to 0 sets pending bit 1 and reloads the count from the threshold, unless a control write or a completion owns the count that cycle. A completion that reloads the timer in the same cycle suppresses this expiry. A timer resting at zero never fires again.
- R7: An error pulse sets pending bit 2.
- R8: A 1 in bit i of the clear input clears pending bit i. If hardware sets the same bit in the same cycle, the bit stays set.
- R9: The interrupt line is a register updated at each clock. After an edge it is high exactly when some pending bit (as updated at that edge) is 1 and the matching enable bit sampled at that edge is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cplPulse | input | 1 | One-cycle end-of-packet completion |
| errPulse | input | 1 | One-cycle error event |
| ctrlWrite | input | 1 | Control word write strobe |
| cplThresh | input | CNT_W | Completion threshold field |
| dlyTimeout | input | TMR_W | Inactivity timeout field, 0 disables |
| irqEnable | input | 3 | Per-source interrupt enables |
| clrPending | input | 3 | Write-one-to-clear strobes |
| tickEn | input | 1 | Prescaled timer tick |
| pending | output | 3 | Pending flags {err, delay, completion} |
| liveCount | output | CNT_W | Current completion count |
| liveTimer | output | TMR_W | Current timer value |
| irqOut | output | 1 | Level interrupt |

## Verification
Two pairs of events can coincide. The first is a hardware set of a pending bit and a software clear of the same bit. The second is a completion and a timer expiry. The bench drives a completion that exhausts the count together with a clear of bit 0, an error pulse together with a clear of bit 2, and a completion in the same tick that would take the timer from 1 to 0. A reference model computed from the requirements predicts the set-wins result for the first pair. For the second pair it predicts the timer reload with no delay flag. A scoreboard compares every cycle against that model.

// File: rtl/icu_pkg.sv
package icu_pkg;
  localparam int NUM_SRC  = 3;
  localparam int SRC_IOC  = 0;
  localparam int SRC_DLY  = 1;
  localparam int SRC_ERR  = 2;

  typedef struct packed {
    logic cntReload;
    logic cntDec;
    logic tmrLoad;
    logic tmrStep;
    logic setIoc;
    logic setDly;
    logic setErr;
  } icu_strobe_t;
endpackage

// File: rtl/icu_ctrl.sv
module icu_ctrl
  import icu_pkg::*;
#(
  parameter int TMR_W = 8
) (
  input  logic             cplPulse,
  input  logic             errPulse,
  input  logic             ctrlWrite,
  input  logic             tickEn,
  input  logic [TMR_W-1:0] dlyTimeout,
  input  logic             cntLeOne,
  input  logic             tmrIsOne,
  input  logic             tmrNonZero,
  output icu_strobe_t      st
);
  logic dlyNonZero;
  logic timerFire;

  always_comb begin
    dlyNonZero   = |dlyTimeout;
    st.tmrLoad   = cplPulse && dlyNonZero;
    st.tmrStep   = tickEn && tmrNonZero && !st.tmrLoad;
    timerFire    = tickEn && tmrIsOne && !st.tmrLoad;
    st.setDly    = timerFire;
    st.setErr    = errPulse;
    st.setIoc    = cplPulse && !ctrlWrite && cntLeOne;
    st.cntReload = ctrlWrite || (cplPulse && cntLeOne) || (!cplPulse && timerFire);
    st.cntDec    = !ctrlWrite && cplPulse && !cntLeOne;
  end
endmodule

// File: rtl/icu_datapath.sv
module icu_datapath
  import icu_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int TMR_W     = 8,
  parameter int RST_COUNT = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  icu_strobe_t        st,
  input  logic [CNT_W-1:0]   cplThresh,
  input  logic [TMR_W-1:0]   dlyTimeout,
  input  logic [NUM_SRC-1:0] irqEnable,
  input  logic [NUM_SRC-1:0] clrPending,
  output logic               cntLeOne,
  output logic               tmrIsOne,
  output logic               tmrNonZero,
  output logic [NUM_SRC-1:0] pending,
  output logic [CNT_W-1:0]   liveCount,
  output logic [TMR_W-1:0]   liveTimer,
  output logic               irqOut
);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [TMR_W-1:0] TMR_ONE  = TMR_W'(1);
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(RST_COUNT);

  logic [CNT_W-1:0]   cntQ;
  logic [TMR_W-1:0]   tmrQ;
  logic [NUM_SRC-1:0] pendQ;
  logic [NUM_SRC-1:0] pendNext;
  logic [NUM_SRC-1:0] setVec;
  logic               irqQ;

  assign setVec = {st.setErr, st.setDly, st.setIoc};

  always_ff @(posedge clk) begin
    if (!rstN)             cntQ <= CNT_INIT;
    else if (st.cntReload) cntQ <= cplThresh;
    else if (st.cntDec)    cntQ <= cntQ - CNT_ONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN)           tmrQ <= '0;
    else if (st.tmrLoad) tmrQ <= dlyTimeout;
    else if (st.tmrStep) tmrQ <= tmrQ - TMR_ONE;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_pend
    assign pendNext[i] = (pendQ[i] && !clrPending[i]) || setVec[i];

    always_ff @(posedge clk) begin
      if (!rstN) pendQ[i] <= 1'b0;
      else       pendQ[i] <= pendNext[i];
    end

    // R8
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
      (clrPending[i] && !setVec[i]) |=> !pending[i]);

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
      setVec[i] |=> pending[i]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= |(pendNext & irqEnable);
  end

  assign cntLeOne   = (cntQ <= CNT_ONE);
  assign tmrIsOne   = (tmrQ == TMR_ONE);
  assign tmrNonZero = |tmrQ;
  assign pending    = pendQ;
  assign liveCount  = cntQ;
  assign liveTimer  = tmrQ;
  assign irqOut     = irqQ;

  // R2
  ioc_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.setIoc |=> (liveCount == $past(cplThresh)));

  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pending == '0) |-> !irqOut);
endmodule

// File: rtl/icu_coalesce.sv
module icu_coalesce
  import icu_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int TMR_W     = 8,
  parameter int RST_COUNT = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cplPulse,
  input  logic               errPulse,
  input  logic               ctrlWrite,
  input  logic [CNT_W-1:0]   cplThresh,
  input  logic [TMR_W-1:0]   dlyTimeout,
  input  logic [NUM_SRC-1:0] irqEnable,
  input  logic [NUM_SRC-1:0] clrPending,
  input  logic               tickEn,
  output logic [NUM_SRC-1:0] pending,
  output logic [CNT_W-1:0]   liveCount,
  output logic [TMR_W-1:0]   liveTimer,
  output logic               irqOut
);
  icu_strobe_t st;
  logic        cntLeOne;
  logic        tmrIsOne;
  logic        tmrNonZero;

  icu_ctrl #(.TMR_W(TMR_W)) u_ctrl (
    .cplPulse   (cplPulse),
    .errPulse   (errPulse),
    .ctrlWrite  (ctrlWrite),
    .tickEn     (tickEn),
    .dlyTimeout (dlyTimeout),
    .cntLeOne   (cntLeOne),
    .tmrIsOne   (tmrIsOne),
    .tmrNonZero (tmrNonZero),
    .st         (st)
  );

  icu_datapath #(.CNT_W(CNT_W), .TMR_W(TMR_W), .RST_COUNT(RST_COUNT)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .st         (st),
    .cplThresh  (cplThresh),
    .dlyTimeout (dlyTimeout),
    .irqEnable  (irqEnable),
    .clrPending (clrPending),
    .cntLeOne   (cntLeOne),
    .tmrIsOne   (tmrIsOne),
    .tmrNonZero (tmrNonZero),
    .pending    (pending),
    .liveCount  (liveCount),
    .liveTimer  (liveTimer),
    .irqOut     (irqOut)
  );

  // R3
  ctrl_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWrite |=> (liveCount == $past(cplThresh)));

  // R4
  tmr_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cplPulse && (dlyTimeout != '0)) |=> (liveTimer == $past(dlyTimeout)));

  // R5
  tmr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !(cplPulse && (dlyTimeout != '0)) && (liveTimer != '0))
      |=> (liveTimer == TMR_W'($past(liveTimer) - 1)));

  // R7
  err_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |=> pending[SRC_ERR]);
endmodule

// File: tb/icu_coalesce_tb.sv
module icu_coalesce_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cplPulse = 1'b0, errPulse = 1'b0, ctrlWrite = 1'b0, tickEn = 1'b0;
  logic [7:0] cplThresh = '0, dlyTimeout = '0;
  logic [2:0] irqEnable = '0, clrPending = '0;
  logic [2:0] pending;
  logic [7:0] liveCount, liveTimer;
  logic       irqOut;

  always #5 clk = ~clk;

  icu_coalesce u_dut (
    .clk(clk), .rstN(rstN), .cplPulse(cplPulse), .errPulse(errPulse),
    .ctrlWrite(ctrlWrite), .cplThresh(cplThresh), .dlyTimeout(dlyTimeout),
    .irqEnable(irqEnable), .clrPending(clrPending), .tickEn(tickEn),
    .pending(pending), .liveCount(liveCount), .liveTimer(liveTimer),
    .irqOut(irqOut)
  );

  typedef struct {
    int         cyc;
    logic [2:0] pend;
    logic [7:0] cnt;
    logic [7:0] tmr;
    logic       irq;
    string      tag;
  } exp_t;

  exp_t       sb[$];
  int         total = 0;
  int         bad = 0;
  int         cycNow = 0;
  bit         done = 0;
  logic [7:0] mCnt, mTmr;
  logic [2:0] mPend;

  always @(posedge clk) cycNow <= cycNow + 1;

  task automatic check(input string tag, input logic [2:0] p, input logic [7:0] c,
                       input logic [7:0] t, input logic q);
    total++;
    if (pending !== p || liveCount !== c || liveTimer !== t || irqOut !== q) begin
      bad++;
      $display("FAIL %s: got pend=%b cnt=%0d tmr=%0d irq=%b exp pend=%b cnt=%0d tmr=%0d irq=%b",
               tag, pending, liveCount, liveTimer, irqOut, p, c, t, q);
    end
  endtask

  // monitor: compares scoreboard entries due in the current cycle
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].cyc == cycNow) begin
      exp_t e;
      e = sb.pop_front();
      check(e.tag, e.pend, e.cnt, e.tmr, e.irq);
    end
  end

  task automatic step(input logic cpl, input logic err, input logic wr,
                      input logic [7:0] thr, input logic [7:0] dly,
                      input logic [2:0] en, input logic [2:0] clr,
                      input logic tick, input string tag);
    logic fire, ld, ioc;
    exp_t e;
    @(negedge clk);
    cplPulse = cpl; errPulse = err; ctrlWrite = wr; cplThresh = thr;
    dlyTimeout = dly; irqEnable = en; clrPending = clr; tickEn = tick;
    ld   = cpl && (dly != 0);
    fire = tick && (mTmr == 1) && !ld;
    ioc  = cpl && !wr && (mCnt <= 1);
    if (wr)       mCnt = thr;
    else if (cpl) mCnt = (mCnt <= 1) ? thr : mCnt - 1;
    else if (fire) mCnt = thr;
    if (ld)                       mTmr = dly;
    else if (tick && mTmr != 0)   mTmr = mTmr - 1;
    mPend = (mPend & ~clr) | {err, fire, ioc};
    e.cyc = cycNow + 1; e.pend = mPend; e.cnt = mCnt; e.tmr = mTmr;
    e.irq = |(mPend & en); e.tag = tag;
    sb.push_back(e);
  endtask

  initial begin
    mCnt = 8'd1; mTmr = 8'd0; mPend = 3'b000;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset", 3'b000, 8'd1, 8'd0, 1'b0);
    step(0,0,1, 3,0, 3'b111,3'b000,0, "R3 write loads count");
    step(1,0,0, 3,0, 3'b111,3'b000,0, "R2 decrement");
    step(1,0,0, 3,0, 3'b111,3'b000,0, "R2 decrement");
    step(1,0,0, 3,0, 3'b111,3'b000,0, "R2 ioc+reload R9");
    step(0,0,0, 3,0, 3'b111,3'b001,0, "R8 clear ioc");
    step(0,0,1, 1,0, 3'b111,3'b000,0, "R3 threshold one");
    step(1,0,0, 1,0, 3'b111,3'b001,0, "R8 set beats clear");
    step(0,0,0, 1,0, 3'b111,3'b001,0, "R8 clear");
    step(0,1,0, 1,0, 3'b000,3'b000,0, "R7 err masked R9");
    step(0,0,0, 1,0, 3'b100,3'b000,0, "R9 enable err");
    step(0,1,0, 1,0, 3'b100,3'b100,0, "R8 err beats clear");
    step(0,0,0, 1,0, 3'b100,3'b100,0, "R8 err clear");
    step(0,0,1, 2,3, 3'b111,3'b000,0, "R3 reload");
    step(1,0,0, 2,3, 3'b111,3'b000,0, "R4 timer load");
    step(0,0,0, 2,3, 3'b111,3'b000,1, "R5 tick");
    step(0,0,0, 2,3, 3'b111,3'b000,0, "R5 hold");
    step(0,0,0, 2,3, 3'b111,3'b000,1, "R5 tick");
    step(0,0,0, 2,3, 3'b111,3'b000,1, "R6 expiry");
    step(0,0,0, 2,3, 3'b111,3'b010,1, "R6 no refire");
    step(1,0,0, 2,3, 3'b111,3'b000,0, "R4 timer load");
    step(0,0,0, 2,3, 3'b111,3'b000,1, "R5 tick");
    step(0,0,0, 2,3, 3'b111,3'b000,1, "R5 tick");
    step(1,0,0, 2,3, 3'b111,3'b000,1, "R6 cpl suppresses expiry");
    step(1,0,1, 1,3, 3'b111,3'b001,0, "R3 write overrides cpl");
    step(0,0,1, 4,0, 3'b111,3'b000,0, "R3 reload");
    step(1,0,0, 4,0, 3'b111,3'b000,0, "R4 zero delay keeps timer");
    step(0,0,0, 4,0, 3'b111,3'b000,0, "R5 idle");
    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      total++; bad++;
      $display("FAIL R9 scoreboard: got %0d left exp 0", sb.size());
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog: got hang exp finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule